// File: doc/BRIEF.md
# Flow-Through Burst Static Memory Model

This block is a synthesizable, small-depth model of a synchronous static memory with a four-beat burst counter and a flow-through read path. The data word is split into byte lanes, and each lane carries one parity bit beside its eight data bits. Address and control inputs are sampled on the rising clock edge.

Two strobes start a burst. The processor-side strobe always starts a read and preempts any burst in progress. The controller-side strobe starts a read, or it writes the lanes whose byte enables are low. Three chip enables decide whether a started burst selects the device. An advance input steps the two-bit burst counter. A static mode input picks linear or interleaved beat order. An asynchronous snooze input freezes the block and releases the bus at once.

Read data is a combinational function of the registered burst address, so it appears in the same cycle the address is registered. The bus drive enable stands for the tri-state control of a bidirectional data bus.

Top module: `burst_sram_model`

## Requirements
- R1: An accepted processor strobe (procStrobeN low, ceN low) registers addrIn on that edge and restarts the burst at beat 0. If the chip enables select, the first beat reads that address.
- R2: An edge that accepts the processor strobe writes nothing, whatever byteWeN, ctrlStrobeN and dataIn are.
- R3: The processor strobe has no effect while ceN is high. With ctrlStrobeN high, the current burst address and selection are kept.
- R4: A burst started while ce2 is low or ce2N is high leaves the device deselected, and dataDrive stays low.
- R5: With burstMode low, the two low address bits of beat k are (start + k) mod 4. The upper address bits stay fixed.
- R6: With burstMode high, the two low address bits of beat k are start XOR k.
- R7: An edge with advanceN low and no strobe steps the beat. After beat 3 the beat returns to 0. With advanceN high the address is held.
- R8: A selected controller strobe with some byteWeN bits low writes dataIn to addrIn on that edge, and only in the enabled lanes. Lane i occupies dataIn bits [9i+8:9i]. Bit 9i+8 is that lane's parity bit, and byteWeN[i] enables the lane.
- R9: dataOut shows the word at the current burst address in the same cycle. dataDrive is high exactly when the device is selected, oeN is low and snooze is low.
- R10: While snooze is high, dataDrive is low at once. No clock edge changes the address, the beat, the selection or the array.
- R11: On an edge with no strobe while the device is selected, low byteWeN bits write the enabled lanes at the current burst address before any advance.
- R12: After reset the device is deselected and dataDrive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| snooze | input | 1 | Active-high asynchronous standby |
| procStrobeN | input | 1 | Processor-side burst start, active low, read only |
| ctrlStrobeN | input | 1 | Controller-side burst start, active low |
| advanceN | input | 1 | Burst advance, active low |
| ceN | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2N | input | 1 | Secondary chip enable, active low |
| burstMode | input | 1 | 0 selects linear order, 1 selects interleaved order |
| oeN | input | 1 | Output enable, active low |
| byteWeN | input | 4 | Per-lane write enables, active low |
| addrIn | input | 6 | Word address |
| dataIn | input | 36 | Write data, four lanes of 8 data bits plus 1 parity bit |
| dataOut | output | 36 | Flow-through read data |
| dataDrive | output | 1 | Bus drive enable, standing for tri-state control |

## Verification
On every cycle the assertions check the restart on the processor strobe and its read-only nature, deselection by the secondary enables, the wrap after beat 3, the freeze under snooze, and that each lane write lands in the array. Only the bench's scenarios show the actual beat orders in both modes, the lane masking as it appears at the read port, and that snooze and a disabled primary enable leave stored and registered values alone. The bench shows these by reading the affected locations back after the stimulus.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int PAR_W  = 1;
  localparam int LANE_W = BYTE_W + PAR_W;
  localparam int DATA_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic [LANES-1:0]  laneWr;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
    logic              drive;
  } memCtl_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              snooze,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              burstMode,
  input  logic              oeN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic [ADDR_W-1:0] addrIn,
  output memCtl_t           memCtl
);
  logic              selReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lowBits;
  logic [ADDR_W-1:0] curAddr;
  logic              procGo, ctrlGo, chipOn;

  assign procGo = !procStrobeN && !ceN;
  assign ctrlGo = !procGo && !ctrlStrobeN;
  assign chipOn = !ceN && ce2 && !ce2N;

  // burst order: interleaved flips bits, linear adds modulo 4
  assign lowBits = burstMode ? (baseAddr[BEAT_W-1:0] ^ beat)
                             : (baseAddr[BEAT_W-1:0] + beat);
  assign curAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= 1'b0;
      baseAddr <= '0;
      beat     <= '0;
    end else if (!snooze) begin
      if (procGo || ctrlGo) begin
        baseAddr <= addrIn;
        beat     <= '0;
        selReg   <= chipOn;
      end else if (selReg && !advanceN) begin
        beat <= beat + 1'b1;
      end
    end
  end

  always_comb begin
    memCtl.laneWr = '0;
    memCtl.wrAddr = curAddr;
    memCtl.rdAddr = curAddr;
    memCtl.drive  = selReg && !oeN && !snooze;
    if (rstN && !snooze && !procGo) begin
      if (ctrlGo) begin
        memCtl.wrAddr = addrIn;
        if (chipOn) memCtl.laneWr = ~byteWeN;
      end else if (selReg) begin
        memCtl.laneWr = ~byteWeN;
      end
    end
  end

  AST_PROC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (procGo && chipOn && !snooze) |=> (selReg && beat == '0 && baseAddr == $past(addrIn))); // R1
  AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ceN) |-> (memCtl.laneWr == '0)); // R2
  AST_CE_BLOCKS_PROC: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && ctrlStrobeN && advanceN && !snooze) |=> ($stable(baseAddr) && $stable(selReg) && $stable(beat))); // R3
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    ((procGo || ctrlGo) && (!ce2 || ce2N) && !snooze) |=> (!selReg && !memCtl.drive)); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (selReg && !advanceN && !procGo && !ctrlGo && !snooze && beat == 2'd3) |=> (beat == '0)); // R7
  AST_SNOOZE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    snooze |=> ($stable(baseAddr) && $stable(beat) && $stable(selReg))); // R10
endmodule

// File: rtl/bsram_data.sv
module bsram_data
  import bsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memCtl_t           memCtl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  assign dataDrive = memCtl.drive;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (memCtl.laneWr[l]) laneMem[memCtl.wrAddr] <= dataIn[l*LANE_W +: LANE_W];
    end

    assign dataOut[l*LANE_W +: LANE_W] = laneMem[memCtl.rdAddr];

    AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      memCtl.laneWr[l] |=> (laneMem[$past(memCtl.wrAddr)] == $past(dataIn[l*LANE_W +: LANE_W]))); // R8
  end
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
  import bsram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              snooze,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              burstMode,
  input  logic              oeN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  memCtl_t memCtl;

  bsram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .snooze(snooze), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .ceN(ceN), .ce2(ce2),
    .ce2N(ce2N), .burstMode(burstMode), .oeN(oeN), .byteWeN(byteWeN),
    .addrIn(addrIn), .memCtl(memCtl)
  );

  bsram_data uData (
    .clk(clk), .rstN(rstN), .memCtl(memCtl), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: tb/tb_burst_sram_model.sv
`timescale 1ns/1ps
module tb_burst_sram_model;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snooze, procStrobeN, ctrlStrobeN, advanceN, ceN, ce2, ce2N, burstMode, oeN;
  logic [NL-1:0] byteWeN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic dataDrive;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] refMem [1 << AW];
  logic refSel = 1'b0;
  logic [AW-1:0] refBase = '0;
  logic [1:0] refBeat = '0;

  always #2.5 clk = ~clk;

  burst_sram_model dut (
    .clk(clk), .rstN(rstN), .snooze(snooze), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .ceN(ceN), .ce2(ce2),
    .ce2N(ce2N), .burstMode(burstMode), .oeN(oeN), .byteWeN(byteWeN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [DW-1:0] wordOf(input int a);
    return (DW'(a) * 36'd1234567) ^ 36'hA5A55A5AF;
  endfunction

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] b, input logic [1:0] k, input logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit pGo, cGo, on;
    logic [AW-1:0] wa;
    logic [NL-1:0] wl;
    if (snooze) return;
    pGo = !procStrobeN && !ceN;
    cGo = !pGo && !ctrlStrobeN;
    on  = !ceN && ce2 && !ce2N;
    wl = '0;
    wa = beatAddr(refBase, refBeat, burstMode);
    if (!pGo) begin
      if (cGo) begin
        wa = addrIn;
        if (on) wl = ~byteWeN;
      end else if (refSel) wl = ~byteWeN;
    end
    for (int l = 0; l < NL; l++)
      if (wl[l]) refMem[wa][l*LW +: LW] = dataIn[l*LW +: LW];
    if (pGo || cGo) begin
      refBase = addrIn; refBeat = '0; refSel = on;
    end else if (refSel && !advanceN) refBeat = refBeat + 1'b1;
  endtask

  task automatic compare(input string tag);
    logic expDrive;
    logic [DW-1:0] expData;
    expDrive = refSel && !oeN && !snooze;
    check(dataDrive == expDrive, tag, DW'(dataDrive), DW'(expDrive));
    if (expDrive) begin
      expData = refMem[beatAddr(refBase, refBeat, burstMode)];
      check(dataOut == expData, tag, dataOut, expData);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    modelEdge();
    #1;
    compare(tag);
  endtask

  task automatic idle();
    snooze = 0; procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    ceN = 0; ce2 = 1; ce2N = 0; oeN = 0; byteWeN = '1;
  endtask

  task automatic procRead(input logic [AW-1:0] a, input string tag);
    idle(); procStrobeN = 0; addrIn = a;
    cyc(tag);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(); burstMode = 0; addrIn = '0; dataIn = '0;
    #1;
    check(dataDrive == 1'b0, "R12 reset", DW'(dataDrive), '0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(dataDrive == 1'b0, "R12 after reset", DW'(dataDrive), '0);

    // fill every word with a known pattern through controller strobe writes (R8)
    for (int a = 0; a < (1 << AW); a++) begin
      idle(); ctrlStrobeN = 0; byteWeN = '0; addrIn = AW'(a); dataIn = wordOf(a);
      cyc("R8 fill");
    end
    idle();

    // R8: lane mask 1010 writes lanes 0 and 2 only
    ctrlStrobeN = 0; byteWeN = 4'b1010; addrIn = 6'd8; dataIn = '1;
    cyc("R8 mask write");
    procRead(6'd8, "R1 read");
    check(dataOut == {wordOf(8)[35:27], 9'h1FF, wordOf(8)[17:9], 9'h1FF}, "R8 lanes", dataOut,
          {wordOf(8)[35:27], 9'h1FF, wordOf(8)[17:9], 9'h1FF});

    // R2: processor strobe with write enables and controller strobe still reads
    idle(); procStrobeN = 0; ctrlStrobeN = 0; byteWeN = '0; addrIn = 6'd9; dataIn = '0;
    cyc("R2");
    idle(); cyc("R2");
    check(dataOut == wordOf(9), "R2 no write", dataOut, wordOf(9));

    // R3: disabled primary enable, processor strobe ignored
    idle(); ceN = 1; procStrobeN = 0; addrIn = 6'd20;
    cyc("R3");
    check(dataDrive && dataOut == wordOf(9), "R3 ignored", dataOut, wordOf(9));
    idle();

    // R4: secondary enables deselect
    idle(); procStrobeN = 0; ce2 = 0; addrIn = 6'd10;
    cyc("R4");
    check(dataDrive == 1'b0, "R4 ce2 low", DW'(dataDrive), '0);
    idle(); procStrobeN = 0; ce2N = 1; addrIn = 6'd10;
    cyc("R4");
    check(dataDrive == 1'b0, "R4 ce2N high", DW'(dataDrive), '0);

    // R5 / R6 / R7: burst order and wrap from start address 17
    for (int m = 0; m < 2; m++) begin
      burstMode = m[0];
      procRead(6'd17, "R1 burst start");
      for (int k = 0; k < 6; k++) begin
        logic [1:0] kk;
        int lo;
        kk = 2'(k);
        lo = m ? (1 ^ kk) : ((1 + kk) % 4);
        check(dataOut == wordOf(16 + lo), m ? "R6 order" : "R5 order", dataOut, wordOf(16 + lo));
        idle(); advanceN = 0;
        cyc("R7 advance");
      end
      idle(); cyc("R7 hold");
      idle(); cyc("R7 hold");
    end
    burstMode = 0;

    // R9: output enable off releases the bus, data path stays flow-through
    procRead(6'd30, "R9 read");
    check(dataOut == wordOf(30), "R9 same cycle", dataOut, wordOf(30));
    oeN = 1; #1;
    check(dataDrive == 1'b0, "R9 oe off", DW'(dataDrive), '0);
    idle();

    // R10: snooze blocks a write and releases the bus
    idle(); snooze = 1; ctrlStrobeN = 0; byteWeN = '0; addrIn = 6'd11; dataIn = '0;
    #1;
    check(dataDrive == 1'b0, "R10 drive off", DW'(dataDrive), '0);
    cyc("R10 snoozed edge");
    procRead(6'd11, "R10 read back");
    check(dataOut == wordOf(11), "R10 no write", dataOut, wordOf(11));

    // R11: continuation write at the current burst address, then advance
    idle(); ctrlStrobeN = 0; addrIn = 6'd12;
    cyc("R11 start");
    idle(); byteWeN = '0; advanceN = 0; dataIn = 36'h123456789;
    cyc("R11 write");
    procRead(6'd12, "R11 read back");
    check(dataOut == 36'h123456789, "R11 data", dataOut, 36'h123456789);

    // random phase compared against the reference model (R5, R6, R8, R9, R11)
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) burstMode = $urandom_range(0, 1);
      snooze      = ($urandom_range(0, 15) == 0);
      procStrobeN = ($urandom_range(0, 5) != 0);
      ctrlStrobeN = ($urandom_range(0, 4) != 0);
      ceN         = ($urandom_range(0, 7) == 0);
      ce2         = ($urandom_range(0, 9) != 0);
      ce2N        = ($urandom_range(0, 9) == 0);
      advanceN    = $urandom_range(0, 1);
      oeN         = ($urandom_range(0, 4) == 0);
      byteWeN     = ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom);
      addrIn      = AW'($urandom);
      dataIn      = {4'($urandom), 32'($urandom)};
      cyc(burstMode ? "R6 random" : "R5 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule